// File: doc/BRIEF.md
# Tagged-Queue HDLC Bit-Stream Transmitter

This block turns bytes taken from an on-chip transmit queue into a synchronous HDLC bit stream. Around each packet it places an opening and a closing 0x7E flag. Inside the packet it adds a zero after any run of five ones, and it appends a 16-bit frame check sequence. A queue entry holds a data byte and two tag bits. The tag bits come from one-shot arming bits in a control register, and a single FIFO write clears them. One tag closes the packet after its byte, so several packets can sit in the queue back to back. The other tag makes the packet end in an abort.

Software writes the control register to set four things: transmit enable, the line state used while the queue is empty (steady ones or repeated flags), transparent mode, and the two tag arming bits. Transparent mode sends raw bytes with no framing. The serial side moves one bit on each clock cycle in which `bit_en` is high, and `tx_bit` holds its value between those cycles. A status pulse reports a mid-packet queue underrun, which the block turns into an abort.

Top module: `hdlc_tx_tagq`

## Requirements
- R1: After reset, `tx_bit` is 1, `fifo_empty` is 1, `fifo_full` is 0, `tx_underrun` is 0, and all control fields are 0, which means the transmitter is disabled.
- R2: The control write fields have fixed positions. Bit 5 is transmit enable. Bit 4 arms the end-of-packet tag. Bit 3 arms the abort tag. Bit 2 selects the idle line (0 = steady ones, 1 = repeated flags). Bit 1 selects transparent mode. Bits 7, 6 and 0 have no effect.
- R3: The queue holds 16 entries. `fifo_empty` and `fifo_full` report its state. A write while the queue is full is dropped.
- R4: An armed tag is attached to the next byte written to the queue, and that write clears the arming bit, so later bytes are untagged.
- R5: A framed packet goes out as the flag 0x7E, then the data bytes, then the FCS, then a closing 0x7E. Every byte goes least significant bit first. The stream advances one bit per cycle with `bit_en` high, and `tx_bit` holds its value otherwise.
- R6: Inside data and FCS bits, a 0 follows every run of five consecutive ones. Flags and abort patterns get no zero insertion.
- R7: The FCS is CRC-16 with polynomial x^16+x^12+x^5+1, processed bit-reflected (0x8408) from a preset of 0xFFFF over the data bytes. It is sent inverted, low byte first.
- R8: After an end-of-packet-tagged byte, the FCS and closing flag follow, and then the next queued packet opens with its own flag.
- R9: A byte carrying the abort tag is not sent. Eight ones without zero insertion go out in its place, with no FCS and no closing flag, and the line then returns to idle handling.
- R10: If the queue is empty when the next data byte of an open packet is due, the block sends eight ones and raises `tx_underrun` for one clock, in the cycle in which the first of those ones appears on `tx_bit`.
- R11: With transmit enabled and the queue empty, the line carries all ones when idle select is 0 and repeated 0x7E flags when it is 1. With transmit disabled the line carries all ones.
- R12: Clearing transmit enable during a packet lets that packet finish, including FCS and closing flag. Queued packets that follow stay in the queue until the transmitter is enabled again, and then they go out.
- R13: In transparent mode, queued bytes go out least significant bit first with no flags, zero insertion, FCS or tag handling. An empty queue gives all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write value |
| fifo_we | input | 1 | Transmit queue write strobe |
| fifo_wdata | input | 8 | Byte written to the transmit queue |
| bit_en | input | 1 | Serial bit clock enable |
| tx_bit | output | 1 | Serial line output |
| fifo_empty | output | 1 | Transmit queue holds no entry |
| fifo_full | output | 1 | Transmit queue holds 16 entries |
| tx_underrun | output | 1 | One-clock pulse when an open packet runs out of data |

## Verification
The byte patterns are chosen to tell the zero-insertion rules apart. Runs of five ones sit inside a byte and also straddle byte boundaries, and one case runs from the last data bit into the FCS. The expected bits, FCS included, are built in the bench from the rules, and the captured line is compared bit for bit. The queue contents separate three packet endings: a close on an end tag, an abort on an abort tag, and an abort on a starved queue. Only the underrun case may pulse the status output. Idle-select, disable-in-packet and transparent runs each show one line behaviour that the framed runs cannot produce. Those behaviours are repeated flags, a queued packet held back, and unframed ones-rich bytes with no inserted zeros.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int BYTE_W    = 8;
  localparam int CRC_W     = 16;
  localparam int STUFF_RUN = 5;

  localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E;
  localparam logic [BYTE_W-1:0] MARK_BYTE = 8'hFF;
  localparam logic [CRC_W-1:0]  CRC_POLY_REFL = 16'h8408;
  localparam logic [CRC_W-1:0]  CRC_PRESET    = 16'hFFFF;

  // control write field positions
  localparam int CB_TX_EN  = 5;
  localparam int CB_EOP    = 4;
  localparam int CB_ABORT  = 3;
  localparam int CB_FILL   = 2;
  localparam int CB_TRANSP = 1;

  typedef struct packed {
    logic tx_en;
    logic arm_eop;
    logic arm_abort;
    logic flag_fill;
    logic transp;
  } ctrl_t;

  typedef struct packed {
    logic              abort_tag;
    logic              eop_tag;
    logic [BYTE_W-1:0] data;
  } txq_entry_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DATA,
    PH_FCS_LO,
    PH_FCS_HI,
    PH_CLOSE
  } tx_phase_t;

  function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c,
                                                     input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ CRC_POLY_REFL;
    end
    return r;
  endfunction
endpackage

// File: rtl/hdlc_tx_rst_sync.sv
module hdlc_tx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [BYTE_W-1:0] ctrl_wdata,
  input  logic              fifo_we,
  output ctrl_t             ctrl
);
  ctrl_t ctrl_q;
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) begin
      ctrl_d.tx_en     = ctrl_wdata[CB_TX_EN];
      ctrl_d.arm_eop   = ctrl_wdata[CB_EOP];
      ctrl_d.arm_abort = ctrl_wdata[CB_ABORT];
      ctrl_d.flag_fill = ctrl_wdata[CB_FILL];
      ctrl_d.transp    = ctrl_wdata[CB_TRANSP];
    end else if (fifo_we) begin
      ctrl_d.arm_eop   = 1'b0;
      ctrl_d.arm_abort = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [AW-1:0]    wr_idx_q, wr_idx_d, rd_idx_q, rd_idx_d;
  logic [CW-1:0]    count_q, count_d;
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0] slot_we;
  logic             push, pop;

  assign empty = (count_q == '0);
  assign full  = (count_q == FULL_CNT);
  assign push  = wr_en && !full;
  assign pop   = rd_en && !empty;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot_we
    assign slot_we[g] = push && (wr_idx_q == AW'(g));
  end

  always_comb begin
    wr_idx_d = wr_idx_q;
    rd_idx_d = rd_idx_q;
    count_d  = count_q;
    if (push) wr_idx_d = (wr_idx_q == LAST_IDX) ? '0 : wr_idx_q + 1'b1;
    if (pop)  rd_idx_d = (rd_idx_q == LAST_IDX) ? '0 : rd_idx_q + 1'b1;
    unique case ({push, pop})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      count_q  <= '0;
    end else begin
      wr_idx_q <= wr_idx_d;
      rd_idx_q <= rd_idx_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) mem_q[i] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_idx_q];
endmodule

// File: rtl/hdlc_tx_serial.sv
module hdlc_tx_serial
  import hdlc_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  ctrl_t      ctrl,
  input  txq_entry_t head,
  input  logic       q_empty,
  output logic       pop,
  output logic       tx_bit,
  output logic       underrun
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam int ONE_W = $clog2(STUFF_RUN + 1);
  localparam logic [ONE_W-1:0] RUN_LIMIT = ONE_W'(STUFF_RUN);

  tx_phase_t         phase_q, phase_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              stuff_q, stuff_d;
  logic [ONE_W-1:0]  ones_q, ones_d;
  logic [CRC_W-1:0]  crc_q, crc_d;
  logic              bit_q, bit_d;
  logic              urun_q, urun_d;

  logic              load;
  logic [BYTE_W-1:0] seg_bits;
  logic              seg_stuff;

  // segment selection at a byte boundary
  always_comb begin
    phase_d   = phase_q;
    crc_d     = crc_q;
    urun_d    = 1'b0;
    pop       = 1'b0;
    seg_bits  = MARK_BYTE;
    seg_stuff = 1'b0;
    load      = bit_en && (ones_q != RUN_LIMIT) && (cnt_q == '0);
    if (load) begin
      unique case (phase_q)
        PH_IDLE: begin
          if (ctrl.tx_en && !q_empty) begin
            if (ctrl.transp) begin
              pop      = 1'b1;
              seg_bits = head.data;
            end else begin
              seg_bits = FLAG_BYTE;
              crc_d    = CRC_PRESET;
              phase_d  = PH_DATA;
            end
          end else if (ctrl.tx_en && ctrl.flag_fill && !ctrl.transp) begin
            seg_bits = FLAG_BYTE;
          end
        end
        PH_DATA: begin
          if (q_empty) begin
            urun_d  = 1'b1;
            phase_d = PH_IDLE;
          end else begin
            pop = 1'b1;
            if (head.abort_tag) begin
              phase_d = PH_IDLE;
            end else begin
              seg_bits  = head.data;
              seg_stuff = 1'b1;
              crc_d     = crc_step_byte(crc_q, head.data);
              if (head.eop_tag) phase_d = PH_FCS_LO;
            end
          end
        end
        PH_FCS_LO: begin
          seg_bits  = ~crc_q[BYTE_W-1:0];
          seg_stuff = 1'b1;
          phase_d   = PH_FCS_HI;
        end
        PH_FCS_HI: begin
          seg_bits  = ~crc_q[CRC_W-1:BYTE_W];
          seg_stuff = 1'b1;
          phase_d   = PH_CLOSE;
        end
        PH_CLOSE: begin
          seg_bits = FLAG_BYTE;
          phase_d  = PH_IDLE;
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  // bit shifting and zero insertion
  always_comb begin
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    stuff_d = stuff_q;
    ones_d  = ones_q;
    bit_d   = bit_q;
    if (bit_en) begin
      if (ones_q == RUN_LIMIT) begin
        bit_d  = 1'b0;
        ones_d = '0;
      end else if (load) begin
        bit_d   = seg_bits[0];
        sh_d    = seg_bits >> 1;
        cnt_d   = CNT_W'(BYTE_W - 1);
        stuff_d = seg_stuff;
        ones_d  = (seg_stuff && seg_bits[0]) ? ones_q + 1'b1 : '0;
      end else begin
        bit_d  = sh_q[0];
        sh_d   = sh_q >> 1;
        cnt_d  = cnt_q - 1'b1;
        ones_d = (stuff_q && sh_q[0]) ? ones_q + 1'b1 : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      sh_q    <= MARK_BYTE;
      cnt_q   <= '0;
      stuff_q <= 1'b0;
      ones_q  <= '0;
      crc_q   <= CRC_PRESET;
      bit_q   <= 1'b1;
      urun_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      stuff_q <= stuff_d;
      ones_q  <= ones_d;
      crc_q   <= crc_d;
      bit_q   <= bit_d;
      urun_q  <= urun_d;
    end
  end

  assign tx_bit   = bit_q;
  assign underrun = urun_q;
endmodule

// File: rtl/hdlc_tx_tagq.sv
module hdlc_tx_tagq
  import hdlc_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [BYTE_W-1:0] ctrl_wdata,
  input  logic              fifo_we,
  input  logic [BYTE_W-1:0] fifo_wdata,
  input  logic              bit_en,
  output logic              tx_bit,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              tx_underrun
);
  localparam int ENTRY_W = $bits(txq_entry_t);

  logic             rst_n_s;
  ctrl_t            ctrl;
  logic             arm_eop, arm_abort;
  txq_entry_t       wr_entry, head;
  logic [ENTRY_W-1:0] head_raw;
  logic             pop;

  hdlc_tx_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  hdlc_tx_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .fifo_we    (fifo_we),
    .ctrl       (ctrl)
  );

  assign arm_eop   = ctrl.arm_eop;
  assign arm_abort = ctrl.arm_abort;

  always_comb begin
    wr_entry.abort_tag = arm_abort;
    wr_entry.eop_tag   = arm_eop;
    wr_entry.data      = fifo_wdata;
  end

  hdlc_tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENTRY_W)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (fifo_we),
    .wr_data (wr_entry),
    .rd_en   (pop),
    .rd_data (head_raw),
    .empty   (fifo_empty),
    .full    (fifo_full)
  );

  assign head = txq_entry_t'(head_raw);

  hdlc_tx_serial u_ser (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .bit_en   (bit_en),
    .ctrl     (ctrl),
    .head     (head),
    .q_empty  (fifo_empty),
    .pop      (pop),
    .tx_bit   (tx_bit),
    .underrun (tx_underrun)
  );
endmodule

// File: rtl/hdlc_tx_tagq_chk.sv
module hdlc_tx_tagq_chk (
  input logic clk,
  input logic rst_n_s,
  input logic ctrl_we,
  input logic fifo_we,
  input logic bit_en,
  input logic tx_bit,
  input logic fifo_empty,
  input logic fifo_full,
  input logic tx_underrun,
  input logic arm_eop,
  input logic arm_abort
);
  p_empty_full_excl_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(fifo_empty && fifo_full));

  p_full_no_drain_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fifo_full && !bit_en) |=> fifo_full);

  p_arm_clear_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fifo_we && !ctrl_we) |=> (!arm_eop && !arm_abort));

  p_line_hold_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bit_en |=> $stable(tx_bit));

  p_underrun_mark_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    tx_underrun |-> tx_bit);

  p_underrun_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    tx_underrun |=> !tx_underrun);
endmodule

bind hdlc_tx_tagq hdlc_tx_tagq_chk u_chk (
  .clk         (clk),
  .rst_n_s     (rst_n_s),
  .ctrl_we     (ctrl_we),
  .fifo_we     (fifo_we),
  .bit_en      (bit_en),
  .tx_bit      (tx_bit),
  .fifo_empty  (fifo_empty),
  .fifo_full   (fifo_full),
  .tx_underrun (tx_underrun),
  .arm_eop     (arm_eop),
  .arm_abort   (arm_abort)
);

// File: tb/tb_hdlc_tx_tagq.sv
module tb_hdlc_tx_tagq;
  logic       clk;
  logic       rst_n;
  logic       ctrl_we;
  logic [7:0] ctrl_wdata;
  logic       fifo_we;
  logic [7:0] fifo_wdata;
  logic       bit_en;
  logic       tx_bit;
  logic       fifo_empty;
  logic       fifo_full;
  logic       tx_underrun;

  int checks;
  int failures;
  int urun_cnt;
  int urun_bad;
  int en_phase;
  bit rst_done;
  bit done;
  bit cap [$];
  bit exp_q [$];
  int eo;
  logic [7:0] pk [$];

  hdlc_tx_tagq dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_we     (ctrl_we),
    .ctrl_wdata  (ctrl_wdata),
    .fifo_we     (fifo_we),
    .fifo_wdata  (fifo_wdata),
    .bit_en      (bit_en),
    .tx_bit      (tx_bit),
    .fifo_empty  (fifo_empty),
    .fifo_full   (fifo_full),
    .tx_underrun (tx_underrun)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // bit enable pattern 1,1,0 and line capture, away from the rising edge
  always @(negedge clk) begin
    if (rst_done) begin
      if (bit_en) cap.push_back(tx_bit);
      if (tx_underrun) begin
        urun_cnt++;
        if (!tx_bit) urun_bad++;
      end
    end
    bit_en   = (en_phase != 2);
    en_phase = (en_phase == 2) ? 0 : en_phase + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    fifo_we = 1'b1; fifo_wdata = b;
    @(negedge clk);
    fifo_we = 1'b0;
  endtask

  task automatic wait_bits(input int n);
    int start;
    start = cap.size();
    while (cap.size() < start + n) @(negedge clk);
  endtask

  task automatic wait_empty();
    while (!fifo_empty) @(negedge clk);
  endtask

  // expected-stream builders
  task automatic e_clear();
    exp_q.delete();
    eo = 0;
  endtask

  task automatic e_pending();
    if (eo == 5) begin
      exp_q.push_back(1'b0);
      eo = 0;
    end
  endtask

  task automatic e_raw(input logic [7:0] b);
    for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
    eo = 0;
  endtask

  task automatic e_flag();
    e_pending();
    e_raw(8'h7E);
  endtask

  task automatic e_abort();
    e_pending();
    e_raw(8'hFF);
  endtask

  task automatic e_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      e_pending();
      exp_q.push_back(b[i]);
      eo = b[i] ? eo + 1 : 0;
    end
  endtask

  function automatic logic [15:0] fcs_of(input logic [7:0] d [$]);
    logic [15:0] r;
    r = 16'hFFFF;
    foreach (d[j]) begin
      for (int i = 0; i < 8; i++) begin
        if (r[0] ^ d[j][i]) r = (r >> 1) ^ 16'h8408;
        else                r = r >> 1;
      end
    end
    return ~r;
  endfunction

  task automatic e_frame(input logic [7:0] d [$]);
    logic [15:0] f;
    f = fcs_of(d);
    e_flag();
    foreach (d[j]) e_byte(d[j]);
    e_byte(f[7:0]);
    e_byte(f[15:8]);
    e_flag();
  endtask

  task automatic check_stream(input string req, input string what, input bit tail_ones);
    int k;
    int bad;
    int zeros;
    k = -1; bad = -1; zeros = 0;
    for (int i = 0; i < cap.size(); i++) begin
      if (cap[i] == 1'b0) begin k = i; break; end
    end
    if (k < 0 || k + exp_q.size() > cap.size()) begin
      chk(1'b0, req, {what, " stream length"}, cap.size(), k + exp_q.size());
      return;
    end
    for (int i = 0; i < exp_q.size(); i++) begin
      if (bad < 0 && cap[k+i] != exp_q[i]) bad = i;
    end
    if (bad < 0) chk(1'b1, req, what, 0, 0);
    else chk(1'b0, req, $sformatf("%s bit %0d", what, bad), int'(cap[k+bad]), int'(exp_q[bad]));
    if (tail_ones) begin
      for (int i = k + exp_q.size(); i < cap.size(); i++) if (!cap[i]) zeros++;
      chk(zeros == 0, req, {what, " trailing zeros"}, zeros, 0);
    end
  endtask

  task automatic check_all_ones(input string req, input string what);
    int zeros;
    zeros = 0;
    foreach (cap[i]) if (!cap[i]) zeros++;
    chk(zeros == 0 && cap.size() > 0, req, what, zeros, 0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      report();
    end
  end

  initial begin
    checks = 0; failures = 0; urun_cnt = 0; urun_bad = 0;
    en_phase = 0; rst_done = 1'b0; done = 1'b0; eo = 0;
    rst_n = 1'b0; ctrl_we = 1'b0; ctrl_wdata = '0;
    fifo_we = 1'b0; fifo_wdata = '0; bit_en = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rst_done = 1'b1;

    // R1 reset state
    chk(tx_bit == 1'b1, "R1", "tx_bit after reset", tx_bit, 1);
    chk(fifo_empty == 1'b1, "R1", "empty after reset", fifo_empty, 1);
    chk(fifo_full == 1'b0, "R1", "full after reset", fifo_full, 0);
    chk(tx_underrun == 1'b0, "R1", "underrun after reset", tx_underrun, 0);
    wait_bits(24);
    check_all_ones("R1", "line while disabled after reset");

    // R2 unused bits do not enable the transmitter
    wr_ctrl(8'hC1);
    push(8'h81);
    cap.delete();
    wait_bits(40);
    check_all_ones("R2", "line with only bits 7,6,0 set");
    chk(fifo_empty == 1'b0, "R2", "byte kept queued", fifo_empty, 0);

    // R3/R5/R6/R7 full queue, one 16-byte packet
    pk = '{8'h81, 8'hFF, 8'h1F, 8'hF8, 8'h00, 8'h7E, 8'h3E, 8'h7C,
           8'hFF, 8'hFF, 8'h55, 8'hAA, 8'h0F, 8'hF0, 8'hE7, 8'h5A};
    for (int j = 1; j < 15; j++) push(pk[j]);
    wr_ctrl(8'h10);
    push(pk[15]);
    chk(fifo_full == 1'b1, "R3", "full at 16 entries", fifo_full, 1);
    push(8'hC3);
    chk(fifo_full == 1'b1, "R3", "full after dropped write", fifo_full, 1);
    cap.delete();
    wr_ctrl(8'h20);
    wait_empty();
    chk(fifo_full == 1'b0, "R3", "not full after drain", fifo_full, 0);
    wait_bits(64);
    e_clear(); e_frame(pk);
    check_stream("R6", "16-byte frame with stuffing, FCS, drop of 17th", 1'b1);

    // R8/R4 two packets queued back to back
    wr_ctrl(8'h00);
    wr_ctrl(8'h10);
    push(8'h55);
    push(8'h33);
    push(8'h0F);
    wr_ctrl(8'h10);
    push(8'hF0);
    cap.delete();
    wr_ctrl(8'h20);
    wait_empty();
    wait_bits(64);
    e_clear();
    pk = '{8'h55}; e_frame(pk);
    pk = '{8'h33, 8'h0F, 8'hF0}; e_frame(pk);
    check_stream("R8", "back-to-back packets, one-shot tag R4", 1'b1);

    // R9 abort tag
    wr_ctrl(8'h00);
    push(8'h12);
    push(8'h34);
    wr_ctrl(8'h08);
    push(8'h56);
    wr_ctrl(8'h10);
    push(8'h9A);
    cap.delete();
    wr_ctrl(8'h20);
    wait_empty();
    wait_bits(64);
    e_clear();
    e_flag(); e_byte(8'h12); e_byte(8'h34); e_abort();
    pk = '{8'h9A}; e_frame(pk);
    check_stream("R9", "abort tag then next packet", 1'b1);
    chk(urun_cnt == 0, "R10", "no underrun pulse for complete packets", urun_cnt, 0);

    // R10 underrun
    cap.delete();
    urun_cnt = 0;
    push(8'hA5);
    wait_empty();
    wait_bits(48);
    e_clear(); e_flag(); e_byte(8'hA5); e_abort();
    check_stream("R10", "starved packet aborts", 1'b1);
    chk(urun_cnt == 1, "R10", "underrun pulse count", urun_cnt, 1);
    chk(urun_bad == 0, "R10", "underrun aligned with ones", urun_bad, 0);

    // R11 flag fill, then back to mark idle
    wr_ctrl(8'h24);
    wait_bits(16);
    cap.delete();
    wait_bits(48);
    begin
      int per_bad;
      int k;
      int fbad;
      per_bad = 0; k = -1; fbad = 0;
      for (int i = 0; i + 8 < cap.size(); i++) if (cap[i] != cap[i+8]) per_bad++;
      for (int i = 0; i + 1 < cap.size(); i++) if (!cap[i] && cap[i+1]) begin k = i; break; end
      if (k < 0 || k + 8 > cap.size()) fbad = 1;
      else for (int i = 0; i < 8; i++) if (cap[k+i] != ((8'h7E >> i) & 8'h01)) fbad++;
      chk(per_bad == 0 && fbad == 0, "R11", "repeated flag fill", per_bad + fbad, 0);
    end
    wr_ctrl(8'h20);
    wait_bits(16);
    cap.delete();
    wait_bits(32);
    check_all_ones("R11", "mark idle when queue empty");

    // R12 disable inside a packet
    wr_ctrl(8'h00);
    push(8'h11);
    push(8'h22);
    push(8'h33);
    wr_ctrl(8'h10);
    push(8'h44);
    wr_ctrl(8'h10);
    push(8'h66);
    cap.delete();
    wr_ctrl(8'h20);
    wait_bits(12);
    wr_ctrl(8'h00);
    wait_bits(120);
    e_clear();
    pk = '{8'h11, 8'h22, 8'h33, 8'h44}; e_frame(pk);
    check_stream("R12", "packet completes after disable", 1'b1);
    chk(fifo_empty == 1'b0, "R12", "next packet held while disabled", fifo_empty, 0);
    cap.delete();
    wr_ctrl(8'h20);
    wait_empty();
    wait_bits(48);
    e_clear();
    pk = '{8'h66}; e_frame(pk);
    check_stream("R12", "held packet sent on re-enable", 1'b1);

    // R13 transparent mode
    wr_ctrl(8'h00);
    push(8'hF8);
    push(8'hFF);
    wr_ctrl(8'h10);
    push(8'h7E);
    push(8'h01);
    cap.delete();
    wr_ctrl(8'h22);
    wait_empty();
    wait_bits(24);
    e_clear();
    e_raw(8'hF8); e_raw(8'hFF); e_raw(8'h7E); e_raw(8'h01);
    check_stream("R13", "transparent bytes without framing", 1'b1);
    chk(urun_cnt == 1, "R13", "no underrun in transparent mode", urun_cnt, 1);

    done = 1'b1;
    report();
  end
endmodule